// File: doc/BRIEF.md
# Lookup Table Indirect Access Port

This block holds a small table of 68-bit entries and exposes it to software only through a narrow register window on a 32-bit register bus. Software stages an entry in three 32-bit data registers. It then writes a table-control register whose low bits name an entry index. Bit 31 of that register picks the direction. When it is set, the staged words are committed into the named entry. When it is clear, the named entry is copied into the staging registers so that software can read it back one word at a time.

The staging words are ordered with the most significant part first. The data register at the lowest offset carries the top four bits of the entry. The next register carries the middle 32 bits, and the last carries the lowest 32 bits. A global control register holds an enable bit that is passed to the surrounding switch logic, and a clear bit that starts a hardware wipe. The wipe visits each entry once per clock and marks it free by zeroing its two-bit type field. The clear bit drops by itself when the wipe is done, and a busy flag can be read while it runs. Searching, aging and forwarding are left to other blocks.

Top module: `lut_access_port`

## Requirements
- R1: After reset, every register offset reads zero, enable_o is 0 and every entry holds zero.
- R2: A write to offset 0x20 with bit 31 set commits the three staged words into the entry whose index is in bits 7:0 of the written value.
- R3: A write to offset 0x20 with bit 31 clear copies the indexed entry into the staging registers, where it can then be read at 0x34, 0x38 and 0x3C.
- R4: Entry bits 67:64 are held in bits 3:0 of the word at 0x34, entry bits 63:32 in the word at 0x38, and entry bits 31:0 in the word at 0x3C. Bits 31:4 of 0x34 always read zero.
- R5: An index at or above DEPTH is ignored by a commit, leaving every entry unchanged. Selecting such an index for readback loads zeros into all three staging words.
- R6: Writing 1 to bit 30 of offset 0x08 starts a wipe that sets entry bits 61:60 (the type field, 00 = free) of every entry to 00 and keeps every other bit. Bit 30 reads back as 0 once the wipe is over, DEPTH cycles after the start.
- R7: While the wipe runs, bit 30 and bit 0 (busy) of offset 0x08 read 1, and writes to offset 0x20 are ignored.
- R8: Bit 31 of offset 0x08 is a read/write enable bit that drives enable_o, one cycle after the write.
- R9: A read returns its data on rdata_o with rvalid_o high in the cycle after the request. Offset 0x20 reads back the last index written there in bits 7:0, and offsets that are not decoded read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| enable_o | output | 1 | Enable bit from the global control register |

## Verification
A corrupted entry or staging bit shows up at the ports on the first readback of that entry. That is three bus reads after the read-select, and the bench reaches it on its sweep over every index. A wrong word order or a lost upper-word mask shows up on the first word read. A wipe pointer that skips an entry, or that fails to stop, shows up as a type field that is still set, or as a busy flag that is still high, when the bench polls DEPTH plus a few cycles after the start. A table-control access that leaks through during the wipe shows up as overwritten data once the wipe is over.

// File: rtl/lut_pkg.sv
package lut_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ENTRY_W  = 68;
  localparam int unsigned HI_W     = ENTRY_W - 2 * WORD_W;
  localparam int unsigned TYPE_LSB = 60;
  localparam int unsigned TYPE_W   = 2;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned IDXF_W   = 8;

  localparam logic [TYPE_W-1:0] TYPE_FREE = '0;

  localparam logic [ADDR_W-1:0] OFF_GCTL  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_TCTL  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_DATA0 = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_DATA1 = 8'h38;
  localparam logic [ADDR_W-1:0] OFF_DATA2 = 8'h3C;

  localparam int unsigned BIT_EN     = 31;
  localparam int unsigned BIT_CLR    = 30;
  localparam int unsigned BIT_BUSY   = 0;
  localparam int unsigned BIT_COMMIT = 31;

  typedef logic [ENTRY_W-1:0] entry_t;
endpackage

// File: rtl/lut_entry_ram.sv
module lut_entry_ram
  import lut_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  entry_t           wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output entry_t           rd_data_o,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i
);
  entry_t mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else if (wr_en_i) begin
      mem[wr_idx_i] <= wr_data_i;
    end else if (clr_en_i) begin
      mem[clr_idx_i][TYPE_LSB +: TYPE_W] <= TYPE_FREE;
    end
  end

  assign rd_data_o = mem[rd_idx_i];

  // R2: a commit lands in the addressed entry
  a_r2_commit_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem[$past(wr_idx_i)] == $past(wr_data_i));
  // R7: table writes never overlap the wipe
  a_r7_no_write_in_wipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !clr_en_i);
  // R6: a wiped entry is free afterwards
  a_r6_entry_freed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> mem[$past(clr_idx_i)][TYPE_LSB +: TYPE_W] == TYPE_FREE);
endmodule

// File: rtl/lut_clear_seq.sv
module lut_clear_seq #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] clr_idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      clr_idx_o <= '0;
    end else if (busy_o) begin
      if (clr_idx_o == LAST) begin
        busy_o    <= 1'b0;
        clr_idx_o <= '0;
      end else begin
        clr_idx_o <= clr_idx_o + 1'b1;
      end
    end else if (start_i) begin
      busy_o    <= 1'b1;
      clr_idx_o <= '0;
    end
  end

  // R6: the wipe ends after the last entry
  a_r6_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && clr_idx_o == LAST) |=> !busy_o);
  // R6: every wipe begins at entry zero
  a_r6_starts_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> clr_idx_o == '0);
endmodule

// File: rtl/lut_reg_slave.sv
module lut_reg_slave
  import lut_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              enable_o,
  input  logic              busy_i,
  output logic              clr_start_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  idx_o,
  output entry_t            stage_o,
  input  entry_t            rd_data_i
);
  logic              wr_req, rd_req, tctl_hit, in_range, select;
  logic [IDXF_W-1:0] idx_field, last_idx;
  entry_t            stage;
  logic [WORD_W-1:0] rmux;

  assign wr_req    = req_i && we_i;
  assign rd_req    = req_i && !we_i;
  assign tctl_hit  = wr_req && addr_i == OFF_TCTL && !busy_i;
  assign idx_field = wdata_i[IDXF_W-1:0];
  assign in_range  = 32'(idx_field) < DEPTH;
  assign idx_o     = IDX_W'(idx_field);
  assign wr_en_o   = tctl_hit && wdata_i[BIT_COMMIT] && in_range;
  assign select    = tctl_hit && !wdata_i[BIT_COMMIT];
  assign clr_start_o = wr_req && addr_i == OFF_GCTL && wdata_i[BIT_CLR] && !busy_i;
  assign stage_o   = stage;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage    <= '0;
      last_idx <= '0;
      enable_o <= 1'b0;
    end else begin
      if (tctl_hit) last_idx <= idx_field;
      if (select) stage <= in_range ? rd_data_i : '0;
      if (wr_req) begin
        unique case (addr_i)
          OFF_GCTL:  enable_o <= wdata_i[BIT_EN];
          OFF_DATA0: stage[ENTRY_W-1 -: HI_W] <= wdata_i[HI_W-1:0];
          OFF_DATA1: stage[2*WORD_W-1 -: WORD_W] <= wdata_i;
          OFF_DATA2: stage[WORD_W-1:0] <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rmux = '0;
    unique case (addr_i)
      OFF_GCTL: begin
        rmux[BIT_EN]   = enable_o;
        rmux[BIT_CLR]  = busy_i;
        rmux[BIT_BUSY] = busy_i;
      end
      OFF_TCTL:  rmux = WORD_W'(last_idx);
      OFF_DATA0: rmux = WORD_W'(stage[ENTRY_W-1 -: HI_W]);
      OFF_DATA1: rmux = stage[2*WORD_W-1 -: WORD_W];
      OFF_DATA2: rmux = stage[WORD_W-1:0];
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= rmux;
    end
  end

  // R4: upper bits of the top word never read as one
  a_r4_top_word_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(addr_i) == OFF_DATA0) |-> rdata_o[WORD_W-1:HI_W] == '0);
  // R5: out-of-range readback yields zeros
  a_r5_oob_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (select && !in_range) |=> stage == '0);
  // R9: read data is valid exactly one cycle after a read request
  a_r9_rvalid_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);
endmodule

// File: rtl/lut_access_port.sv
module lut_access_port
  import lut_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        rvalid_o,
  output logic        enable_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             busy, clr_start, wr_en;
  logic [IDX_W-1:0] idx, clr_idx;
  entry_t           stage, rd_data;

  lut_reg_slave #(.DEPTH(DEPTH)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .rvalid_o, .enable_o,
    .busy_i(busy), .clr_start_o(clr_start), .wr_en_o(wr_en),
    .idx_o(idx), .stage_o(stage), .rd_data_i(rd_data)
  );

  lut_clear_seq #(.DEPTH(DEPTH)) u_clr (
    .clk_i, .rst_ni, .start_i(clr_start), .busy_o(busy), .clr_idx_o(clr_idx)
  );

  lut_entry_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(idx), .wr_data_i(stage),
    .rd_idx_i(idx), .rd_data_o(rd_data),
    .clr_en_i(busy), .clr_idx_i(clr_idx)
  );

  // R8: enable output follows the written bit
  a_r8_enable_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_GCTL) |=> enable_o == $past(wdata_i[BIT_EN]));
endmodule

// File: tb/sim_lut_access_port.sv
module sim_lut_access_port;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, enable;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lut_access_port #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .enable_o(enable)
  );

  function automatic logic [67:0] pat(int i);
    return {4'(i * 3 + 1), 32'(i * 32'h0101_0107 ^ 32'h5A00_3C00), 32'(~(i * 32'h0001_9E37))};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
    checks++;
    if (rvalid !== 1'b1) begin
      fails++;
      $display("FAIL R9 rvalid got=%b exp=1", rvalid);
    end
  endtask

  task automatic put_entry(int i, logic [67:0] e);
    bus_wr(8'h34, {28'h0, e[67:64]});
    bus_wr(8'h38, e[63:32]);
    bus_wr(8'h3C, e[31:0]);
    bus_wr(8'h20, 32'h8000_0000 | 32'(i));
  endtask

  task automatic get_entry(int i, string tag, logic [67:0] e);
    logic [31:0] d;
    bus_wr(8'h20, 32'(i));
    bus_rd(8'h34, d); chk({tag, " word0"}, d, {28'h0, e[67:64]});
    bus_rd(8'h38, d); chk({tag, " word1"}, d, e[63:32]);
    bus_rd(8'h3C, d); chk({tag, " word2"}, d, e[31:0]);
  endtask

  initial begin
    logic [31:0] d;
    logic [67:0] typ_mask;
    typ_mask = 68'h3 << 60;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 enable_o", 32'(enable), 32'h0);
    bus_rd(8'h08, d); chk("R1 gctl", d, 0);
    bus_rd(8'h20, d); chk("R1 tctl", d, 0);
    for (int i = 0; i < DEPTH; i++) get_entry(i, "R1 entry", '0);

    // R8: enable bit
    bus_wr(8'h08, 32'h8000_0000);
    chk("R8 enable_o set", 32'(enable), 32'h1);
    bus_rd(8'h08, d); chk("R8 gctl readback", d, 32'h8000_0000);

    // R2/R3/R4: commit and read back every entry
    for (int i = 0; i < DEPTH; i++) put_entry(i, pat(i));
    for (int i = DEPTH - 1; i >= 0; i--) get_entry(i, "R2 R3 R4 entry", pat(i));

    // R4: upper bits of word0 stay zero after writing all ones
    bus_wr(8'h34, 32'hFFFF_FFFF);
    bus_rd(8'h34, d); chk("R4 word0 mask", d, 32'h0000_000F);

    // R9: index readback and undecoded offset
    bus_wr(8'h20, 32'h0000_0007);
    bus_rd(8'h20, d); chk("R9 tctl index", d, 32'h7);
    bus_rd(8'h24, d); chk("R9 undecoded", d, 32'h0);

    // R5: out-of-range commits leave the table intact
    put_entry(DEPTH, 68'hF_FFFF_FFFF_FFFF_FFFF);
    put_entry(255, 68'hF_FFFF_FFFF_FFFF_FFFF);
    for (int i = 0; i < DEPTH; i++) get_entry(i, "R5 untouched", pat(i));
    bus_wr(8'h34, 32'hF); bus_wr(8'h38, 32'h1234_5678); bus_wr(8'h3C, 32'h9ABC_DEF0);
    bus_wr(8'h20, 32'(DEPTH));
    bus_rd(8'h34, d); chk("R5 oob word0", d, 0);
    bus_rd(8'h38, d); chk("R5 oob word1", d, 0);
    bus_rd(8'h3C, d); chk("R5 oob word2", d, 0);

    // R6/R7: wipe
    bus_wr(8'h08, 32'hC000_0000);
    bus_rd(8'h08, d); chk("R7 busy during wipe", d, 32'hC000_0001);
    bus_wr(8'h38, 32'hFFFF_FFFF);
    bus_wr(8'h20, 32'h8000_0003);
    repeat (DEPTH + 4) @(negedge clk);
    bus_rd(8'h08, d); chk("R6 clear self-cleared", d, 32'h8000_0000);
    for (int i = 0; i < DEPTH; i++) get_entry(i, "R6 R7 wiped", pat(i) & ~typ_mask);

    // R8: enable off
    bus_wr(8'h08, 32'h0);
    chk("R8 enable_o clear", 32'(enable), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule